// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of one eight-input interrupt controller. Each request line is captured into a pending register, either on a rising transition (edge mode) or by following the line level (level mode), chosen per line. Pending lines that are not masked compete in a priority search. The search starts at a run-time priority base and walks upward modulo the line count. A request is raised toward the processor only when the best pending line strictly outranks the best line already in service.

An acknowledge strobe moves the current winner into service. In edge mode it also retires the pending bit; a level line stays pending for as long as it is held. With automatic end-of-interrupt enabled, the in-service bit is not kept. That mode can also rotate the priority base so that the line just served becomes the lowest priority. A nesting mode exempts the cascade line's in-service bit from the comparison, so that a downstream controller can interrupt its own service routine. The request and the winning line number leave the block through registers. Register programming, cascading and vector formation are handled around the block.

Top module: `irq_rank_resolver`

## Requirements
- R1: A synchronous reset clears pending, in-service, last-level state and the priority base to 0. During reset and on the first cycle after it, `irq_out` is 0 and `win_line` is 0.
- R2: A line with `trig_level` bit = 0 (edge mode) becomes pending only on a cycle where it is 1 and its previous sampled level was 0. A line held high after acknowledge does not become pending again until it has dropped to 0 and risen again.
- R3: A line with `trig_level` bit = 1 (level mode) is pending exactly while its request input was 1 on the previous cycle. Dropping the line withdraws the request even if it was never acknowledged.
- R4: A masked line (`mask` bit = 1) takes no part in the search, but its pending bit is kept. Clearing the mask bit lets it compete again.
- R5: The rank of line i is (i − base) mod 8, rank 0 being the highest. The winner is the unmasked pending line of lowest rank, so lines are visited in the order base, base+1, … mod 8. `base_we` = 1 loads `base_in` into the base.
- R6: `irq_out` is raised only when the best pending rank is strictly smaller than the best in-service rank. A pending line of equal or lower priority than a line in service raises nothing.
- R7: When `sfn_mode` = 1 and the instance is the master (`IS_MASTER` = 1), in-service bit `CASCADE_LINE` (default 2) is left out of the in-service rank.
- R8: An acknowledge (`ack` = 1) while a request stands sets the winner's in-service bit. It clears the winner's pending bit only in edge mode. An acknowledge with no request standing changes nothing.
- R9: With `auto_eoi` = 1, an acknowledge leaves the in-service bit clear. If `rot_on_aeoi` = 1 as well, the base becomes (winner + 1) mod 8. When `base_we` = 1 in the same cycle, the loaded value takes priority.
- R10: If an edge-mode line is acknowledged in the same cycle that it rises again, it stays pending.
- R11: `irq_out` and `win_line` are registered. They show the resolution of the state and inputs seen at the previous clock edge, and `win_line` is 0 whenever `irq_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | N_LINES | Interrupt request lines |
| trig_level | input | N_LINES | Per-line trigger mode: 0 edge, 1 level |
| mask | input | N_LINES | Per-line mask, 1 removes the line from the search |
| base_we | input | 1 | Load strobe for the priority base |
| base_in | input | IW | New priority base (line of rank 0) |
| auto_eoi | input | 1 | Automatic end-of-interrupt at acknowledge |
| rot_on_aeoi | input | 1 | Rotate base past the winner on automatic end-of-interrupt |
| sfn_mode | input | 1 | Ignore the cascade line's in-service bit in the comparison |
| ack | input | 1 | Acknowledge strobe from the processor |
| irq_out | output | 1 | Registered interrupt request toward the processor |
| win_line | output | IW | Registered number of the winning line |

## Verification
Acknowledge and a fresh rising edge can land on the same line in the same cycle. Here the pending-set path and the acknowledge-clear path compete for one bit. The bench provokes this by letting a captured line fall, then raising it again in the very cycle the acknowledge is driven, with automatic end-of-interrupt on so that service does not hide the result. It then expects the same line to be reported again. A base load can likewise coincide with an acknowledge that would rotate the base. Random cycles across all eight bases mix both events, and a cycle model in the bench, built from the requirements, judges every output.

// File: rtl/irq_rank_pkg.sv
package irq_rank_pkg;

  // Per-line trigger selection.
  typedef enum logic {
    TRIG_EDGE  = 1'b0,
    TRIG_LEVEL = 1'b1
  } trig_mode_e;

  // Index width for a line count (at least one bit).
  function automatic int unsigned line_idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/irq_prio_search.sv
// Rotated first-one search: returns the rank (distance from base) of the
// first set bit visiting base, base+1, ... modulo N_LINES; N_LINES if none.
module irq_prio_search #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IW      = 3
) (
  input  logic [N_LINES-1:0] vec_i,
  input  logic [IW-1:0]      base_i,
  output logic [IW:0]        rank_o
);
  localparam int unsigned RW = IW + 1;

  logic [N_LINES-1:0] rot;

  for (genvar k = 0; k < N_LINES; k++) begin : g_rot
    logic [IW-1:0] idx;
    assign idx    = base_i + IW'(k);
    assign rot[k] = vec_i[idx];
  end

  always_comb begin
    rank_o = RW'(N_LINES);
    for (int k = N_LINES - 1; k >= 0; k--) begin
      if (rot[k]) rank_o = RW'(k);
    end
  end

endmodule

// File: rtl/irq_pend_capture.sv
// Pending register with per-line edge or level capture.
module irq_pend_capture
  import irq_rank_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] trig_i,
  input  logic               grant_i,
  input  logic [IW-1:0]      grant_line_i,
  output logic [N_LINES-1:0] pend_o
);
  logic [N_LINES-1:0] last_q;
  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] pend_d;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      if (trig_i[i] == TRIG_LEVEL) begin
        pend_d[i] = req_i[i];
      end else if (req_i[i] && !last_q[i]) begin
        // a fresh edge wins over a same-cycle acknowledge
        pend_d[i] = 1'b1;
      end else if (grant_i && (grant_line_i == IW'(i))) begin
        pend_d[i] = 1'b0;
      end else begin
        pend_d[i] = pend_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
      pend_q <= '0;
    end else begin
      last_q <= req_i;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/irq_service_regs.sv
// In-service register and rotating priority base.
module irq_service_regs #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IW      = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               grant_i,
  input  logic [IW-1:0]      grant_line_i,
  input  logic               auto_eoi_i,
  input  logic               rot_aeoi_i,
  input  logic               base_we_i,
  input  logic [IW-1:0]      base_in_i,
  output logic [N_LINES-1:0] isr_o,
  output logic [IW-1:0]      base_o
);
  logic [N_LINES-1:0] isr_q;
  logic [IW-1:0]      base_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      isr_q  <= '0;
      base_q <= '0;
    end else begin
      if (grant_i && !auto_eoi_i) isr_q[grant_line_i] <= 1'b1;
      if (base_we_i) begin
        base_q <= base_in_i;
      end else if (grant_i && auto_eoi_i && rot_aeoi_i) begin
        base_q <= grant_line_i + IW'(1);
      end
    end
  end

  assign isr_o  = isr_q;
  assign base_o = base_q;

endmodule

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver
  import irq_rank_pkg::*;
#(
  parameter int unsigned N_LINES      = 8,
  parameter bit          IS_MASTER    = 1'b1,
  parameter int unsigned CASCADE_LINE = 2,
  localparam int unsigned IW          = line_idx_w(N_LINES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] trig_level,
  input  logic [N_LINES-1:0] mask,
  input  logic               base_we,
  input  logic [IW-1:0]      base_in,
  input  logic               auto_eoi,
  input  logic               rot_on_aeoi,
  input  logic               sfn_mode,
  input  logic               ack,
  output logic               irq_out,
  output logic [IW-1:0]      win_line
);
  localparam logic [N_LINES-1:0] SFN_HOLE =
    IS_MASTER ? (N_LINES'(1) << CASCADE_LINE) : '0;

  logic [N_LINES-1:0] pend_q;
  logic [N_LINES-1:0] isr_q;
  logic [IW-1:0]      base_q;
  logic [N_LINES-1:0] pend_eff;
  logic [N_LINES-1:0] isr_eff;
  logic [IW:0]        rank_pend;
  logic [IW:0]        rank_svc;
  logic               hit_c;
  logic [IW-1:0]      win_c;
  logic               grant;

  assign pend_eff = pend_q & ~mask;
  assign isr_eff  = sfn_mode ? (isr_q & ~SFN_HOLE) : isr_q;

  irq_prio_search #(.N_LINES(N_LINES), .IW(IW)) u_pend_search (
    .vec_i (pend_eff),
    .base_i(base_q),
    .rank_o(rank_pend)
  );

  irq_prio_search #(.N_LINES(N_LINES), .IW(IW)) u_svc_search (
    .vec_i (isr_eff),
    .base_i(base_q),
    .rank_o(rank_svc)
  );

  assign hit_c = rank_pend < rank_svc;
  assign win_c = rank_pend[IW-1:0] + base_q;
  assign grant = ack && hit_c;

  irq_pend_capture #(.N_LINES(N_LINES), .IW(IW)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_in),
    .trig_i      (trig_level),
    .grant_i     (grant),
    .grant_line_i(win_c),
    .pend_o      (pend_q)
  );

  irq_service_regs #(.N_LINES(N_LINES), .IW(IW)) u_service (
    .clk         (clk),
    .rst         (rst),
    .grant_i     (grant),
    .grant_line_i(win_c),
    .auto_eoi_i  (auto_eoi),
    .rot_aeoi_i  (rot_on_aeoi),
    .base_we_i   (base_we),
    .base_in_i   (base_in),
    .isr_o       (isr_q),
    .base_o      (base_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out  <= 1'b0;
      win_line <= '0;
    end else begin
      irq_out  <= hit_c;
      win_line <= hit_c ? win_c : '0;
    end
  end

endmodule

// File: rtl/irq_rank_resolver_chk.sv
module irq_rank_resolver_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IW      = 3
) (
  input logic               clk,
  input logic               rst,
  input logic [N_LINES-1:0] req_in,
  input logic [N_LINES-1:0] trig_level,
  input logic [N_LINES-1:0] mask,
  input logic [N_LINES-1:0] pend_q,
  input logic [N_LINES-1:0] isr_q,
  input logic [IW-1:0]      base_q,
  input logic [IW-1:0]      base_in,
  input logic [IW-1:0]      win_c,
  input logic [IW-1:0]      win_line,
  input logic               grant,
  input logic               base_we,
  input logic               auto_eoi,
  input logic               rot_on_aeoi,
  input logic               irq_out
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!irq_out && (win_line == '0) && (pend_q == '0) && (isr_q == '0)));

  // R6
  req_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
    ((pend_q & ~mask) == '0) |=> !irq_out);

  // R3
  level_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pend_q & $past(trig_level)) == ($past(req_in) & $past(trig_level))));

  // R8
  ack_in_service_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && !auto_eoi) |=> isr_q[$past(win_c)]);

  // R9
  aeoi_rotate_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && auto_eoi && rot_on_aeoi && !base_we) |=> (base_q == IW'($past(win_c) + IW'(1))));

  // R9
  base_load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    base_we |=> (base_q == $past(base_in)));

  // R11
  idle_line_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_out |-> (win_line == '0));

endmodule

bind irq_rank_resolver irq_rank_resolver_chk #(.N_LINES(N_LINES), .IW(IW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_in     (req_in),
  .trig_level (trig_level),
  .mask       (mask),
  .pend_q     (pend_q),
  .isr_q      (isr_q),
  .base_q     (base_q),
  .base_in    (base_in),
  .win_c      (win_c),
  .win_line   (win_line),
  .grant      (grant),
  .base_we    (base_we),
  .auto_eoi   (auto_eoi),
  .rot_on_aeoi(rot_on_aeoi),
  .irq_out    (irq_out)
);

// File: tb/tb_irq_rank_resolver.sv
module tb_irq_rank_resolver;
  localparam int N  = 8;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  req_in = '0, trig_level = '0, mask = '0;
  logic          base_we = 1'b0;
  logic [IW-1:0] base_in = '0;
  logic          auto_eoi = 1'b0, rot_on_aeoi = 1'b0, sfn_mode = 1'b0, ack = 1'b0;
  logic          irq_out;
  logic [IW-1:0] win_line;

  int checks = 0;
  int errors = 0;

  // bench cycle model, built from the requirements
  logic [N-1:0]  m_pend = '0, m_isr = '0, m_last = '0;
  logic [IW-1:0] m_base = '0;
  logic          e_irq = 1'b0;
  logic [IW-1:0] e_win = '0;

  always #10 clk = ~clk;

  irq_rank_resolver #(.N_LINES(N)) dut (
    .clk(clk), .rst(rst), .req_in(req_in), .trig_level(trig_level), .mask(mask),
    .base_we(base_we), .base_in(base_in), .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi),
    .sfn_mode(sfn_mode), .ack(ack), .irq_out(irq_out), .win_line(win_line)
  );

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    summary();
    $finish;
  end

  // returns {hit, win}
  function automatic logic [IW:0] resolve(input logic [N-1:0] pend, input logic [N-1:0] msk,
                                          input logic [N-1:0] isr, input logic [IW-1:0] base,
                                          input logic sfn);
    int pr = N;
    int sr = N;
    for (int j = 0; j < N; j++) begin
      int ln = (int'(base) + j) % N;
      if (pr == N && pend[ln] && !msk[ln]) pr = j;
      if (sr == N && isr[ln] && !(sfn && ln == 2)) sr = j;
    end
    if (pr < sr) return {1'b1, IW'((pr + int'(base)) % N)};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one clock: advance model, then compare registered outputs
  task automatic tick(input string tag);
    logic [IW:0] r;
    logic        grant;
    if (rst) begin
      m_pend = '0; m_isr = '0; m_last = '0; m_base = '0; e_irq = 0; e_win = '0;
    end else begin
      r = resolve(m_pend, mask, m_isr, m_base, sfn_mode);
      grant = ack && r[IW];
      for (int i = 0; i < N; i++) begin
        if (trig_level[i]) m_pend[i] = req_in[i];
        else if (req_in[i] && !m_last[i]) m_pend[i] = 1'b1;
        else if (grant && r[IW-1:0] == IW'(i)) m_pend[i] = 1'b0;
      end
      m_last = req_in;
      if (grant && !auto_eoi) m_isr[r[IW-1:0]] = 1'b1;
      if (base_we) m_base = base_in;
      else if (grant && auto_eoi && rot_on_aeoi) m_base = r[IW-1:0] + IW'(1);
      e_irq = r[IW];
      e_win = r[IW-1:0];
    end
    @(posedge clk);
    @(negedge clk);
    check({tag, " irq_out"}, 8'(irq_out), 8'(e_irq));
    check({tag, " win_line"}, 8'(win_line), 8'(e_win));
  endtask

  task automatic ticks(input string tag, input int n);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic expect_out(input string tag, input logic irq, input int win);
    check({tag, " direct irq"}, 8'(irq_out), 8'(irq));
    check({tag, " direct line"}, 8'(win_line), 8'(win));
  endtask

  task automatic do_reset();
    rst = 1'b1; req_in = '0; trig_level = '0; mask = '0; ack = 0; base_we = 0;
    auto_eoi = 0; rot_on_aeoi = 0; sfn_mode = 0;
    ticks("R1", 2);
    rst = 1'b0;
  endtask

  task automatic pulse_ack(input string tag);
    ack = 1'b1; tick(tag); ack = 1'b0;
  endtask

  task automatic load_base(input string tag, input int b);
    base_we = 1'b1; base_in = IW'(b); tick(tag); base_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    expect_out("R1", 0, 0);
    tick("R1");
    expect_out("R1", 0, 0);

    // R2 edge capture, R8 acknowledge, R6 strict compare
    req_in[3] = 1; ticks("R2", 2);
    expect_out("R2", 1, 3);
    pulse_ack("R8"); ticks("R8", 2);
    expect_out("R2", 0, 0);            // held high: no re-capture
    pulse_ack("R8"); ticks("R8", 2);   // ack with nothing standing
    expect_out("R8", 0, 0);
    req_in[3] = 0; tick("R2"); req_in[3] = 1; ticks("R6", 2);
    expect_out("R6", 0, 0);            // equal rank to in-service: no request
    req_in[1] = 1; ticks("R6", 2);
    expect_out("R6", 1, 1);

    // R3 level mode
    do_reset();
    trig_level[5] = 1; req_in[5] = 1; ticks("R3", 2);
    expect_out("R3", 1, 5);
    req_in[5] = 0; ticks("R3", 2);
    expect_out("R3", 0, 0);
    req_in[5] = 1; ticks("R3", 2);
    pulse_ack("R8"); ticks("R8", 2);   // level line stays pending, blocked by service
    auto_eoi = 1; tick("R8");

    // R4 mask keeps pending
    do_reset();
    req_in[6] = 1; mask[6] = 1; tick("R4"); req_in[6] = 0; ticks("R4", 2);
    expect_out("R4", 0, 0);
    mask[6] = 0; tick("R11");          // one registered cycle
    expect_out("R11", 1, 6);

    // R5 rotation by base load
    do_reset();
    req_in[2] = 1; req_in[6] = 1;
    load_base("R5", 5); ticks("R5", 2);
    expect_out("R5", 1, 6);
    load_base("R5", 7); ticks("R5", 2);
    expect_out("R5", 1, 2);

    // R7 nesting mode on the cascade line
    do_reset();
    req_in[2] = 1; ticks("R7", 2);
    pulse_ack("R7");
    req_in[4] = 1; ticks("R7", 2);
    expect_out("R7", 0, 0);
    sfn_mode = 1; ticks("R7", 2);
    expect_out("R7", 1, 4);

    // R9 automatic end of interrupt with rotation
    do_reset();
    auto_eoi = 1; rot_on_aeoi = 1;
    req_in[3] = 1; ticks("R9", 2);
    pulse_ack("R9");
    req_in[1] = 1; req_in[6] = 1; ticks("R9", 2);
    expect_out("R9", 1, 6);            // base now 4
    ack = 1; base_we = 1; base_in = 3'd0; tick("R9");
    ack = 0; base_we = 0; ticks("R9", 2);
    expect_out("R9", 1, 1);            // loaded base 0 beat the rotation

    // R10 acknowledge meets a new edge on the same line
    do_reset();
    auto_eoi = 1;
    req_in[4] = 1; ticks("R10", 2); req_in[4] = 0; ticks("R10", 2);
    expect_out("R10", 1, 4);
    ack = 1; req_in[4] = 1; tick("R10"); ack = 0; ticks("R10", 2);
    expect_out("R10", 1, 4);

    // random mix over all eight bases
    begin
      int seed = 32'h5eed;
      void'($urandom(seed));
    end
    for (int b = 0; b < N; b++) begin
      do_reset();
      load_base("R5", b);
      for (int c = 0; c < 60; c++) begin
        req_in      = N'($urandom);
        trig_level  = N'($urandom) & N'($urandom);
        mask        = N'($urandom) & N'($urandom);
        ack         = ($urandom % 3) == 0;
        auto_eoi    = ($urandom % 4) == 0;
        rot_on_aeoi = $urandom % 2;
        sfn_mode    = ($urandom % 4) == 0;
        base_we     = ($urandom % 16) == 0;
        base_in     = IW'($urandom);
        tick("R6");
      end
      ack = 0; base_we = 0;
    end

    summary();
    $finish;
  end
endmodule